// File: doc/BRIEF.md
# Shadow Stack Atomic Swap Unit

This unit carries out one atomic swap on shadow-stack memory. It takes an address and a data value from the register file, checks that the current privilege level may use the shadow stack, checks that the address is aligned to the access size, and then performs a locked read followed by a write to the same address. The old memory value comes back sign-extended to the register width, ready to be written to the destination register.

A pipeline issues an operation with a one-cycle `start` pulse while the unit is idle. The unit keeps its own copy of every operand, so the issuing stage may change its operands at once. It ends each operation with a one-cycle `done` pulse that carries a fault code. The access checks run in a fixed order: the machine-level enable, then whether supervisor mode exists (parameter `HAS_SUPER`), then the user-level enable. The first check that fails gives the result. Address translation and the memory system are outside the unit.

Top module: `ss_swap_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `rdWrite`, `memReq` and `memLock` are all low.
- R2: In any privilege level other than machine (`privLvl` 2'b11), with `mEnable` clear, the operation ends with fault code 1 (illegal) and makes no memory request.
- R3: In user level (`privLvl` 2'b00), with `mEnable` set and `sEnable` clear, the operation ends with fault code 1. With `mEnable` clear the result is fault code 1 whatever the value of `sEnable`.
- R4: In machine level the operation goes ahead whatever the values of `mEnable` and `sEnable`.
- R5: A legal operation whose address is not aligned to the access size (4 bytes for a word, 8 for a doubleword) ends with fault code 2 and makes no memory request. An illegal-instruction fault takes priority over misalignment.
- R6: Timing of a legal operation. The read request (`memReq`=1, `memWrite`=0) starts in the second cycle after `start`. The write request follows in the cycle after the read is acknowledged. `memLock` stays high from the read request until the write is acknowledged. `done` is a single-cycle pulse.
- R7: The write carries the low 4 bytes of `dataIn` for a word access, with the upper bits zero, or all of `dataIn` for a doubleword access. `memDouble` gives the access size.
- R8: On success (fault code 0), `rdWrite` is high with `done`. `rdValue` then holds the old memory value, sign-extended from bit 31 for a word access, or unchanged for a doubleword access.
- R9: When the memory reports an error on the read or on the write, the operation ends with fault code 3 and `rdWrite` stays low. A read error prevents the write.
- R10: The read request carries acquire = `acqOrder` and release = `acqOrder`&`relOrder`. The write request carries acquire = `acqOrder`&`relOrder` and release = `relOrder`.
- R11: A `start` that arrives while `busy` is high is ignored. The operation already running keeps its operands, and no second operation follows.
- R12: When `done` is high with a non-zero fault code, `faultAddr` equals the address of the operation. Otherwise `faultAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse, accepted while idle |
| privLvl | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| mEnable | input | 1 | Machine-level shadow-stack enable |
| sEnable | input | 1 | Supervisor-level shadow-stack enable for user level |
| isDouble | input | 1 | 1 selects a doubleword access, 0 selects a word access |
| acqOrder | input | 1 | Acquire ordering bit |
| relOrder | input | 1 | Release ordering bit |
| addrIn | input | XLEN | Swap address |
| dataIn | input | XLEN | New value to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| faultCode | output | 2 | 0 none, 1 illegal, 2 misaligned, 3 access |
| faultAddr | output | XLEN | Address of the operation when it faulted |
| rdWrite | output | 1 | Write rdValue to the destination register |
| rdValue | output | XLEN | Old memory value, sign-extended |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 write, 0 read |
| memLock | output | 1 | Read-modify-write lock |
| memDouble | output | 1 | Access size of the request |
| memAcq | output | 1 | Acquire ordering of the request |
| memRel | output | 1 | Release ordering of the request |
| memAddr | output | XLEN | Request address |
| memWdata | output | XLEN | Write data |
| memAck | input | 1 | Response for the current request |
| memErr | input | 1 | Response carries a fault |
| memRdata | input | XLEN | Read data |

## Verification
The edge that samples `start` moves the unit into its check state. A check fault shows on `done` one cycle later. A read-side access fault shows two cycles later, and a completed swap or a write-side fault three cycles later, when the memory answers in the cycle it is asked. For each operation the bench derives the expected latency from its vector and counts falling edges until `done`, so a result that comes early or late is caught. The bench memory model samples the request lines on falling edges, and records there each read and write, with its lock, ordering bits and data, for comparison after `done`.

// File: rtl/ss_swap_pkg.sv
package ss_swap_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_ILLEGAL  = 2'd1,
    FLT_MISALIGN = 2'd2,
    FLT_ACCESS   = 2'd3
  } fault_e;

  localparam logic [1:0] PRIV_USER    = 2'b00;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operands at issue
    logic loadOld;  // latch read data
    logic isWrite;  // current request is the write half
  } dpStrobe_t;
endpackage

// File: rtl/ss_swap_dp.sv
module ss_swap_dp
  import ss_swap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter bit HAS_SUPER = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [1:0]      privLvl,
  input  logic            mEnable,
  input  logic            sEnable,
  input  logic            isDouble,
  input  logic            acqOrder,
  input  logic            relOrder,
  input  logic [XLEN-1:0] addrIn,
  input  logic [XLEN-1:0] dataIn,
  input  logic [XLEN-1:0] memRdata,
  output fault_e          checkFault,
  output logic [XLEN-1:0] addrOut,
  output logic [XLEN-1:0] wdataOut,
  output logic            dblOut,
  output logic            acqOut,
  output logic            relOut,
  output logic [XLEN-1:0] rdValue
);
  localparam int WORD_BITS = 32;
  localparam bit DBL_OK = (XLEN >= 64);

  logic [XLEN-1:0] addrReg, dataReg, oldReg;
  logic [1:0]      privReg;
  logic            mEnReg, sEnReg, dblReg, aqReg, rlReg;
  logic [XLEN-1:0] wordExt, wordWr;
  logic            misaligned;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0; dataReg <= '0; oldReg <= '0; privReg <= PRIV_MACHINE;
      mEnReg <= 1'b0; sEnReg <= 1'b0; dblReg <= 1'b0; aqReg <= 1'b0; rlReg <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrReg <= addrIn; dataReg <= dataIn; privReg <= privLvl;
        mEnReg <= mEnable; sEnReg <= sEnable; dblReg <= isDouble;
        aqReg <= acqOrder; rlReg <= relOrder;
      end
      if (strobe.loadOld) oldReg <= memRdata;
    end
  end

  generate
    if (XLEN > WORD_BITS) begin : gWide
      assign wordExt = {{(XLEN-WORD_BITS){oldReg[WORD_BITS-1]}}, oldReg[WORD_BITS-1:0]};
      assign wordWr  = {{(XLEN-WORD_BITS){1'b0}}, dataReg[WORD_BITS-1:0]};
      assign misaligned = dblReg ? (addrReg[2:0] != 3'b000) : (addrReg[1:0] != 2'b00);
    end else begin : gNarrow
      assign wordExt = oldReg;
      assign wordWr  = dataReg;
      assign misaligned = (addrReg[1:0] != 2'b00);
    end
  endgenerate

  // ordered access checks: machine enable, supervisor presence, user enable
  always_comb begin
    if (privReg != PRIV_MACHINE && !mEnReg)     checkFault = FLT_ILLEGAL;
    else if (!HAS_SUPER)                        checkFault = FLT_ILLEGAL;
    else if (privReg == PRIV_USER && !sEnReg)   checkFault = FLT_ILLEGAL;
    else if (dblReg && !DBL_OK)                 checkFault = FLT_ILLEGAL;
    else if (misaligned)                        checkFault = FLT_MISALIGN;
    else                                        checkFault = FLT_NONE;
  end

  assign addrOut  = addrReg;
  assign dblOut   = dblReg;
  assign wdataOut = dblReg ? dataReg : wordWr;
  assign rdValue  = dblReg ? oldReg : wordExt;
  assign acqOut   = strobe.isWrite ? (aqReg & rlReg) : aqReg;
  assign relOut   = strobe.isWrite ? rlReg : (aqReg & rlReg);

  // R3: with machine enable clear outside machine level the result is illegal
  assert_menable_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (privReg != PRIV_MACHINE && !mEnReg) |-> checkFault == FLT_ILLEGAL);
endmodule

// File: rtl/ss_swap_ctrl.sv
module ss_swap_ctrl
  import ss_swap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  fault_e    checkFault,
  input  logic      memAck,
  input  logic      memErr,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWrite,
  output logic      memLock,
  output logic      busy,
  output logic      done,
  output fault_e    faultCode
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_WRITE, S_FINISH} state_e;
  state_e state, stateNext;
  fault_e faultReg, faultNext;

  always_comb begin
    stateNext = state;
    faultNext = faultReg;
    strobe    = '0;
    case (state)
      S_IDLE: if (start) begin
        stateNext = S_CHECK; faultNext = FLT_NONE; strobe.capture = 1'b1;
      end
      S_CHECK: begin
        if (checkFault != FLT_NONE) begin stateNext = S_FINISH; faultNext = checkFault; end
        else stateNext = S_READ;
      end
      S_READ: if (memAck) begin
        if (memErr) begin stateNext = S_FINISH; faultNext = FLT_ACCESS; end
        else begin stateNext = S_WRITE; strobe.loadOld = 1'b1; end
      end
      S_WRITE: begin
        strobe.isWrite = 1'b1;
        if (memAck) begin
          stateNext = S_FINISH;
          faultNext = memErr ? FLT_ACCESS : FLT_NONE;
        end
      end
      S_FINISH: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; faultReg <= FLT_NONE;
    end else begin
      state <= stateNext; faultReg <= faultNext;
    end
  end

  assign memReq    = (state == S_READ) || (state == S_WRITE);
  assign memWrite  = (state == S_WRITE);
  assign memLock   = memReq;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);
  assign faultCode = faultReg;

  assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memLock) |-> $past(memAck));
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrite) |-> $past(memReq && !memWrite && memAck && !memErr));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_check_fault_no_mem_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && checkFault != FLT_NONE) |=> !memReq);
  assert_read_err_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memAck && memErr) |=> !memWrite);
endmodule

// File: rtl/ss_swap_unit.sv
module ss_swap_unit
  import ss_swap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter bit HAS_SUPER = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      privLvl,
  input  logic            mEnable,
  input  logic            sEnable,
  input  logic            isDouble,
  input  logic            acqOrder,
  input  logic            relOrder,
  input  logic [XLEN-1:0] addrIn,
  input  logic [XLEN-1:0] dataIn,
  output logic            busy,
  output logic            done,
  output logic [1:0]      faultCode,
  output logic [XLEN-1:0] faultAddr,
  output logic            rdWrite,
  output logic [XLEN-1:0] rdValue,
  output logic            memReq,
  output logic            memWrite,
  output logic            memLock,
  output logic            memDouble,
  output logic            memAcq,
  output logic            memRel,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic            memAck,
  input  logic            memErr,
  input  logic [XLEN-1:0] memRdata
);
  dpStrobe_t strobe;
  fault_e    checkFault, faultE;
  logic [XLEN-1:0] oldExt;

  ss_swap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .checkFault(checkFault),
    .memAck(memAck), .memErr(memErr), .strobe(strobe), .memReq(memReq),
    .memWrite(memWrite), .memLock(memLock), .busy(busy), .done(done),
    .faultCode(faultE)
  );

  ss_swap_dp #(.XLEN(XLEN), .HAS_SUPER(HAS_SUPER)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .privLvl(privLvl),
    .mEnable(mEnable), .sEnable(sEnable), .isDouble(isDouble),
    .acqOrder(acqOrder), .relOrder(relOrder), .addrIn(addrIn), .dataIn(dataIn),
    .memRdata(memRdata), .checkFault(checkFault), .addrOut(memAddr),
    .wdataOut(memWdata), .dblOut(memDouble), .acqOut(memAcq), .relOut(memRel),
    .rdValue(oldExt)
  );

  assign faultCode = faultE;
  assign rdWrite   = done && (faultE == FLT_NONE);
  assign rdValue   = oldExt;
  assign faultAddr = (done && faultE != FLT_NONE) ? memAddr : '0;

  assert_aligned_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memDouble ? (memAddr[2:0] == 3'b000) : (memAddr[1:0] == 2'b00)));
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(memAddr));
endmodule

// File: tb/sim_ss_swap_unit.sv
module sim_ss_swap_unit;
  localparam int XLEN = 64;

  typedef struct packed {
    logic [1:0]  priv;
    logic        mEn, sEn, dbl, aq, rl, errRd, errWr;
    logic [63:0] addr, data, mem;
    logic [1:0]  expCode;
    logic [63:0] expRd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R4 machine ignores enables, doubleword
    '{2'b11,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,64'h1000,64'h1122334455667788,64'hAAAABBBBCCCCDDDD,2'd0,64'hAAAABBBBCCCCDDDD},
    // R8 supervisor word, negative sign extension
    '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h2004,64'hFFFFFFFF87654321,64'h0123456789ABCDEF,2'd0,64'hFFFFFFFF89ABCDEF},
    // R8 user word, positive
    '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,64'h3008,64'h00000000CAFEF00D,64'h1111111170000001,2'd0,64'h0000000070000001},
    // R2 supervisor with machine enable clear
    '{2'b01,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,64'h4000,64'h5,64'h6,2'd1,64'h0},
    // R3 user with machine enable clear, user enable set
    '{2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,64'h4010,64'h5,64'h6,2'd1,64'h0},
    // R3 user with user enable clear
    '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h4020,64'h5,64'h6,2'd1,64'h0},
    // R5 doubleword misaligned
    '{2'b01,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,64'h4004,64'h5,64'h6,2'd2,64'h0},
    // R5 word misaligned
    '{2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h4002,64'h5,64'h6,2'd2,64'h0},
    // R5 illegal wins over misaligned
    '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h4001,64'h5,64'h6,2'd1,64'h0},
    // R9 read error
    '{2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,64'h5000,64'h7,64'h8,2'd3,64'h0},
    // R9 write error
    '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,64'h6000,64'h7,64'h8,2'd3,64'h0},
    // R10 release only, doubleword
    '{2'b11,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,64'h7008,64'hDEADBEEF01234567,64'h8000000000000001,2'd0,64'h8000000000000001}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] privLvl = 2'b11;
  logic mEnable = 1'b0, sEnable = 1'b0, isDouble = 1'b0, acqOrder = 1'b0, relOrder = 1'b0;
  logic [XLEN-1:0] addrIn = '0, dataIn = '0;
  logic busy, done, rdWrite, memReq, memWrite, memLock, memDouble, memAcq, memRel;
  logic [1:0] faultCode;
  logic [XLEN-1:0] faultAddr, rdValue, memAddr, memWdata;
  logic memAck = 1'b0, memErr = 1'b0;
  logic [XLEN-1:0] memRdata = '0;

  int checks = 0, errors = 0;
  logic errRd = 1'b0, errWr = 1'b0;
  logic [63:0] memWord = '0;
  int rdSeen, wrSeen;
  logic rdAcq, rdRel, wrAcq, wrRel, wrDbl, lockBad;
  logic [63:0] wrData, wrAddr;

  always #5 clk = ~clk;

  ss_swap_unit #(.XLEN(XLEN), .HAS_SUPER(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .privLvl(privLvl), .mEnable(mEnable),
    .sEnable(sEnable), .isDouble(isDouble), .acqOrder(acqOrder), .relOrder(relOrder),
    .addrIn(addrIn), .dataIn(dataIn), .busy(busy), .done(done), .faultCode(faultCode),
    .faultAddr(faultAddr), .rdWrite(rdWrite), .rdValue(rdValue), .memReq(memReq),
    .memWrite(memWrite), .memLock(memLock), .memDouble(memDouble), .memAcq(memAcq),
    .memRel(memRel), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memErr(memErr), .memRdata(memRdata)
  );

  // memory model: answers in the cycle it is asked, records requests
  always @(negedge clk) begin
    memAck   = memReq;
    memErr   = memReq && ((!memWrite && errRd) || (memWrite && errWr));
    memRdata = memWord;
    if (memReq && !memLock) lockBad = 1'b1;
    if (memReq && !memWrite) begin rdSeen++; rdAcq = memAcq; rdRel = memRel; end
    if (memReq && memWrite) begin
      wrSeen++; wrAcq = memAcq; wrRel = memRel; wrData = memWdata; wrAddr = memAddr; wrDbl = memDouble;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    privLvl = v.priv; mEnable = v.mEn; sEnable = v.sEn; isDouble = v.dbl;
    acqOrder = v.aq; relOrder = v.rl; addrIn = v.addr; dataIn = v.data;
    memWord = v.mem; errRd = v.errRd; errWr = v.errWr;
    rdSeen = 0; wrSeen = 0; lockBad = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int lat, expLat, expRds, expWrs;
    logic [63:0] expW;
    expLat = (v.expCode == 2'd1 || v.expCode == 2'd2) ? 1 : (v.errRd ? 2 : 3);
    expRds = (expLat == 1) ? 0 : 1;
    expWrs = (expLat == 3) ? 1 : 0;
    expW   = v.dbl ? v.data : {32'h0, v.data[31:0]};
    issue(v);
    lat = 0;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == expLat, $sformatf("R6 latency vec%0d", idx), 64'(lat), 64'(expLat));
    chk(faultCode == v.expCode, $sformatf("R2 R3 R5 R9 code vec%0d", idx), 64'(faultCode), 64'(v.expCode));
    chk(rdWrite == (v.expCode == 2'd0), $sformatf("R8 rdWrite vec%0d", idx), 64'(rdWrite), 64'(v.expCode == 2'd0));
    if (v.expCode == 2'd0)
      chk(rdValue == v.expRd, $sformatf("R8 rdValue vec%0d", idx), rdValue, v.expRd);
    chk(faultAddr == ((v.expCode != 2'd0) ? v.addr : 64'h0), $sformatf("R12 faultAddr vec%0d", idx),
        faultAddr, (v.expCode != 2'd0) ? v.addr : 64'h0);
    chk(rdSeen == expRds && wrSeen == expWrs, $sformatf("R5 R9 access count vec%0d", idx),
        64'(rdSeen * 16 + wrSeen), 64'(expRds * 16 + expWrs));
    chk(!lockBad, $sformatf("R6 lock vec%0d", idx), 64'(lockBad), 64'h0);
    if (expRds == 1)
      chk(rdAcq == v.aq && rdRel == (v.aq & v.rl), $sformatf("R10 read order vec%0d", idx),
          {62'h0, rdAcq, rdRel}, {62'h0, v.aq, v.aq & v.rl});
    if (expWrs == 1) begin
      chk(wrAcq == (v.aq & v.rl) && wrRel == v.rl, $sformatf("R10 write order vec%0d", idx),
          {62'h0, wrAcq, wrRel}, {62'h0, v.aq & v.rl, v.rl});
      chk(wrData == expW && wrDbl == v.dbl && wrAddr == v.addr, $sformatf("R7 write data vec%0d", idx), wrData, expW);
    end
    @(negedge clk);
    chk(!done && !busy, $sformatf("R6 done pulse vec%0d", idx), {62'h0, done, busy}, 64'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t busyV;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rdWrite && !memReq && !memLock, "R1 reset idle",
        {59'h0, busy, done, rdWrite, memReq, memLock}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq, "R1 idle after reset", {62'h0, busy, memReq}, 64'h0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R11 start while busy is ignored
    busyV = VECS[0];
    issue(busyV);
    start = 1'b1; addrIn = 64'h9000; dataIn = 64'h99; isDouble = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk(wrSeen == 1 && wrAddr == busyV.addr && wrData == busyV.data, "R11 busy start ignored",
        wrAddr, busyV.addr);
    chk(!busy, "R11 no second operation", 64'(busy), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule